// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general-purpose registers of a 32-bit processor core. The core presents a 4-bit logical register number on each of two read ports and one write port, together with its current 5-bit operating mode. The block resolves every logical number to a physical register. Some registers are common to all modes. Others are private copies that belong to one exception mode. This lets an exception handler use its own stack pointer and link register, and in fast-interrupt mode its own r8 to r14, without saving the interrupted program's values first.

Every exception mode also owns one saved-status register. It has a separate read port and write port, and the current mode selects which copy they reach. User and system modes have no saved-status register. In those modes the read port returns the live status word supplied by the core, and a write is dropped.

Reads are combinational from the stored state. A write is committed on the rising clock edge. Reset is an active-low asynchronous reset that clears all storage.

Top module: `banked_regfile`

## Requirements
- R1: After reset every general register in every bank and every saved-status register reads as zero.
- R2: Mode codes are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Each exception mode reaches its own bank.
- R3: Logical r0 to r7 and r15 are one physical copy shared by every mode. A value written in one mode is read back unchanged in any other mode.
- R4: In fast-interrupt mode, r8 to r14 map to seven private registers. Writing them does not change the user copies, and the reverse also holds.
- R5: Supervisor, abort, interrupt and undefined modes each have private r13 and r14. They share r8 to r12 with user mode.
- R6: User and system modes see the same register set.
- R7: Each of the five exception modes has its own saved-status register. A write in one exception mode is read back in that mode and does not change the other copies.
- R8: In user or system mode, the saved-status read returns cur_sts_i unchanged, and a saved-status write changes no stored copy.
- R9: When a read and a write reach the same physical register in the same cycle, the read shows the old value. The new value is readable from the following cycle.
- R10: The two read ports are independent. Each returns the register it addresses in the same cycle.
- R11: Any mode code not listed in R2 uses the user-mode register mapping, and its saved-status read returns cur_sts_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current operating mode code |
| rd_a_addr_i | input | 4 | Logical register number, read port A |
| rd_a_data_o | output | 32 | Read data, port A |
| rd_b_addr_i | input | 4 | Logical register number, read port B |
| rd_b_data_o | output | 32 | Read data, port B |
| wr_en_i | input | 1 | General register write enable |
| wr_addr_i | input | 4 | Logical register number to write |
| wr_data_i | input | 32 | Write data |
| cur_sts_i | input | 32 | Live status word from the core |
| sts_wr_en_i | input | 1 | Saved-status write enable |
| sts_wr_data_i | input | 32 | Saved-status write data |
| sts_rd_data_o | output | 32 | Saved-status read data |

## Verification
Read results on both ports and on the saved-status port are combinational, so they are due in the same cycle that the address and mode are applied. The bench drives its inputs on the falling edge and compares shortly after, well before the next rising edge. A write takes effect at the next rising edge, so read-back is checked no earlier than the falling edge that follows it. The read-during-write case is compared twice. It expects the old value in the cycle of the write and the new value one cycle later.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
  localparam int DATA_W    = 32;
  localparam int LOG_W     = 4;
  localparam int MODE_W    = 5;
  localparam int NUM_PHYS  = 31;
  localparam int PHYS_W    = $clog2(NUM_PHYS);
  localparam int NUM_SAVED = 5;
  localparam int FIQ_BASE  = 16;
  localparam int EXC_BASE  = FIQ_BASE + 7;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BANK_USR = 3'd0,
    BANK_FIQ = 3'd1,
    BANK_SVC = 3'd2,
    BANK_ABT = 3'd3,
    BANK_IRQ = 3'd4,
    BANK_UND = 3'd5
  } bank_e;

  // logical register + bank -> physical slot
  // 0..15 user set, 16..22 fiq r8..r14, 23.. pairs of r13/r14 per other exception bank
  function automatic logic [PHYS_W-1:0] map_phys(bank_e bank, logic [LOG_W-1:0] addr);
    logic [PHYS_W-1:0] idx;
    idx = PHYS_W'(addr);
    if (bank == BANK_FIQ && addr >= 4'd8 && addr <= 4'd14)
      idx = PHYS_W'(FIQ_BASE + int'(addr) - 8);
    else if (bank != BANK_USR && bank != BANK_FIQ && addr >= 4'd13 && addr <= 4'd14)
      idx = PHYS_W'(EXC_BASE + 2 * (int'(bank) - int'(BANK_SVC)) + int'(addr) - 13);
    return idx;
  endfunction
endpackage

// File: rtl/bank_decode.sv
module bank_decode
  import banked_rf_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o
);
  always_comb begin
    unique case (mode_i)
      MODE_FIQ: bank_o = BANK_FIQ;
      MODE_SVC: bank_o = BANK_SVC;
      MODE_ABT: bank_o = BANK_ABT;
      MODE_IRQ: bank_o = BANK_IRQ;
      MODE_UND: bank_o = BANK_UND;
      default:  bank_o = BANK_USR; // user, system, unknown
    endcase
  end
endmodule

// File: rtl/phys_store.sv
module phys_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_PHYS = 31,
  parameter int PHYS_W   = $clog2(NUM_PHYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PHYS_W-1:0] widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PHYS_W-1:0] ridx_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [PHYS_W-1:0] ridx_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] regs [NUM_PHYS];

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (we_i && widx_i == PHYS_W'(g))      q <= wdata_i;
    end
    assign regs[g] = q;
  end

  always_comb begin
    rdata_a_o = (int'(ridx_a_i) < NUM_PHYS) ? regs[ridx_a_i] : '0;
    rdata_b_o = (int'(ridx_b_i) < NUM_PHYS) ? regs[ridx_b_i] : '0;
  end
endmodule

// File: rtl/sts_bank.sv
module sts_bank
  import banked_rf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NSAVE = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bank_e         bank_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] cur_sts_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] saved [NSAVE];
  logic [2:0]    sel;

  for (genvar g = 0; g < NSAVE; g++) begin : g_sts
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= '0;
      else if (we_i && bank_i == bank_e'(3'(g + 1))) q <= wdata_i;
    end
    assign saved[g] = q;
  end

  assign sel = 3'(bank_i) - 3'd1;

  always_comb begin
    if (bank_i == BANK_USR || int'(sel) >= NSAVE) rdata_o = cur_sts_i;
    else                                          rdata_o = saved[sel];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [LOG_W-1:0]  rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [LOG_W-1:0]  rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [LOG_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] cur_sts_i,
  input  logic              sts_wr_en_i,
  input  logic [DATA_W-1:0] sts_wr_data_i,
  output logic [DATA_W-1:0] sts_rd_data_o
);
  bank_e             bank;
  logic [PHYS_W-1:0] ridx_a, ridx_b, widx;

  bank_decode u_dec (
    .mode_i (mode_i),
    .bank_o (bank)
  );

  assign ridx_a = map_phys(bank, rd_a_addr_i);
  assign ridx_b = map_phys(bank, rd_b_addr_i);
  assign widx   = map_phys(bank, wr_addr_i);

  phys_store #(
    .DATA_W   (DATA_W),
    .NUM_PHYS (NUM_PHYS),
    .PHYS_W   (PHYS_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en_i),
    .widx_i    (widx),
    .wdata_i   (wr_data_i),
    .ridx_a_i  (ridx_a),
    .rdata_a_o (rd_a_data_o),
    .ridx_b_i  (ridx_b),
    .rdata_b_o (rd_b_data_o)
  );

  sts_bank #(
    .DW    (DATA_W),
    .NSAVE (NUM_SAVED)
  ) u_sts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bank_i    (bank),
    .we_i      (sts_wr_en_i),
    .wdata_i   (sts_wr_data_i),
    .cur_sts_i (cur_sts_i),
    .rdata_o   (sts_rd_data_o)
  );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import banked_rf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MODE_W-1:0] mode_i,
  input logic [LOG_W-1:0]  rd_a_addr_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [LOG_W-1:0]  rd_b_addr_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic              wr_en_i,
  input logic [LOG_W-1:0]  wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] cur_sts_i,
  input logic              sts_wr_en_i,
  input logic [DATA_W-1:0] sts_wr_data_i,
  input logic [DATA_W-1:0] sts_rd_data_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  logic exc_mode;
  assign exc_mode = mode_i inside {MODE_FIQ, MODE_SVC, MODE_ABT, MODE_IRQ, MODE_UND};

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !past_ok |-> (rd_a_data_o == '0 && rd_b_data_o == '0));

  // R9
  write_next_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(wr_en_i) && $stable(mode_i) && rd_a_addr_i == $past(wr_addr_i))
    |-> rd_a_data_o == $past(wr_data_i));

  // R3
  shared_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(wr_en_i) && ($past(wr_addr_i) < 4'd8 || $past(wr_addr_i) == 4'd15)
     && rd_b_addr_i == $past(wr_addr_i))
    |-> rd_b_data_o == $past(wr_data_i));

  // R10
  ports_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_addr_i == rd_b_addr_i |-> rd_a_data_o == rd_b_data_o);

  // R8
  user_sts_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_USR || mode_i == MODE_SYS) |-> sts_rd_data_o == cur_sts_i);

  // R7
  sts_write_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(sts_wr_en_i) && $stable(mode_i) && exc_mode)
    |-> sts_rd_data_o == $past(sts_wr_data_i));

  // R9
  hold_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(wr_en_i) && $stable(mode_i) && $stable(rd_a_addr_i))
    |-> $stable(rd_a_data_o));
endmodule

bind banked_regfile banked_regfile_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_i        (mode_i),
  .rd_a_addr_i   (rd_a_addr_i),
  .rd_a_data_o   (rd_a_data_o),
  .rd_b_addr_i   (rd_b_addr_i),
  .rd_b_data_o   (rd_b_data_o),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_data_i     (wr_data_i),
  .cur_sts_i     (cur_sts_i),
  .sts_wr_en_i   (sts_wr_en_i),
  .sts_wr_data_i (sts_wr_data_i),
  .sts_rd_data_o (sts_rd_data_o)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  import banked_rf_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic [MODE_W-1:0] mode;
  logic [LOG_W-1:0]  ra, rb, wa;
  logic [DATA_W-1:0] rda, rdb, wd, cur_sts, swd, srd;
  logic              we, swe;

  banked_regfile uut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .mode_i        (mode),
    .rd_a_addr_i   (ra),
    .rd_a_data_o   (rda),
    .rd_b_addr_i   (rb),
    .rd_b_data_o   (rdb),
    .wr_en_i       (we),
    .wr_addr_i     (wa),
    .wr_data_i     (wd),
    .cur_sts_i     (cur_sts),
    .sts_wr_en_i   (swe),
    .sts_wr_data_i (swd),
    .sts_rd_data_o (srd)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int          port;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  chk_ev;
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // monitor: compare 1 time unit after inputs change, well before the rising edge
  initial begin : monitor
    item_t       it;
    logic [31:0] act;
    forever begin
      @(chk_ev);
      #1;
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        case (it.port)
          0:       act = rda;
          1:       act = rdb;
          default: act = srd;
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(int port, logic [31:0] exp, string tag);
    item_t it;
    it.port = port; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic rd_a(logic [4:0] m, logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    mode = m; ra = a;
    push(0, exp, tag);
    -> chk_ev;
  endtask

  task automatic rd_ab(logic [4:0] m, logic [3:0] a, logic [3:0] b,
                       logic [31:0] ea, logic [31:0] eb, string tag);
    @(negedge clk);
    mode = m; ra = a; rb = b;
    push(0, ea, tag);
    push(1, eb, tag);
    -> chk_ev;
  endtask

  task automatic rd_sts(logic [4:0] m, logic [31:0] cur, logic [31:0] exp, string tag);
    @(negedge clk);
    mode = m; cur_sts = cur;
    push(2, exp, tag);
    -> chk_ev;
  endtask

  task automatic wr(logic [4:0] m, logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    mode = m; wa = a; wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic sts_wr(logic [4:0] m, logic [31:0] d);
    @(negedge clk);
    mode = m; swd = d; swe = 1'b1;
    @(negedge clk);
    swe = 1'b0;
  endtask

  task automatic raw(logic [4:0] m, logic [3:0] a, logic [31:0] old_v, logic [31:0] new_v);
    @(negedge clk);
    mode = m; wa = a; wd = new_v; we = 1'b1; ra = a;
    push(0, old_v, "R9 read during write gives old");
    -> chk_ev;
    @(negedge clk);
    we = 1'b0;
    push(0, new_v, "R9 new value next cycle");
    -> chk_ev;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : driver
    rst_ni = 1'b0;
    mode = MODE_USR; ra = '0; rb = '0; wa = '0; wd = '0; we = 1'b0;
    cur_sts = '0; swd = '0; swe = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd_ab(MODE_USR, 4'd0, 4'd13, 32'h0, 32'h0, "R1 user r0/r13 zero");
    rd_ab(MODE_FIQ, 4'd8, 4'd14, 32'h0, 32'h0, "R1 fiq r8/r14 zero");
    rd_sts(MODE_SVC, 32'hFFFF_FFFF, 32'h0, "R1 svc saved status zero");
    rd_sts(MODE_UND, 32'hFFFF_FFFF, 32'h0, "R1 und saved status zero");

    // R3 shared registers
    wr(MODE_USR, 4'd0, 32'hA000_0000);
    rd_a(MODE_FIQ, 4'd0, 32'hA000_0000, "R3 r0 shared into fiq");
    rd_a(MODE_SVC, 4'd0, 32'hA000_0000, "R3 r0 shared into svc");
    wr(MODE_IRQ, 4'd15, 32'hF000_0015);
    rd_a(MODE_USR, 4'd15, 32'hF000_0015, "R3 r15 shared into user");
    wr(MODE_FIQ, 4'd7, 32'h0000_0707);
    rd_a(MODE_ABT, 4'd7, 32'h0000_0707, "R3 r7 shared from fiq");

    // R4 fiq bank
    wr(MODE_USR, 4'd8, 32'h5500_0008);
    wr(MODE_USR, 4'd13, 32'h5500_0013);
    wr(MODE_USR, 4'd14, 32'h5500_0014);
    wr(MODE_FIQ, 4'd8, 32'hF100_0008);
    wr(MODE_FIQ, 4'd13, 32'hF100_0013);
    rd_a(MODE_FIQ, 4'd8, 32'hF100_0008, "R4 fiq r8 private");
    rd_a(MODE_USR, 4'd8, 32'h5500_0008, "R4 user r8 untouched");
    rd_ab(MODE_FIQ, 4'd12, 4'd13, 32'h0, 32'hF100_0013, "R4 fiq r12 private/r13");
    rd_a(MODE_USR, 4'd13, 32'h5500_0013, "R4 user r13 untouched");

    // R5 other exception banks
    rd_a(MODE_SVC, 4'd8, 32'h5500_0008, "R5 svc shares r8");
    rd_a(MODE_SVC, 4'd13, 32'h0, "R5 svc r13 private zero");
    wr(MODE_SVC, 4'd13, 32'h5C00_0013);
    rd_a(MODE_SVC, 4'd13, 32'h5C00_0013, "R5 svc r13 written");
    rd_a(MODE_ABT, 4'd13, 32'h0, "R2 abt r13 separate");
    rd_a(MODE_USR, 4'd13, 32'h5500_0013, "R5 user r13 untouched by svc");
    wr(MODE_ABT, 4'd14, 32'hAB00_0014);
    rd_a(MODE_UND, 4'd14, 32'h0, "R2 und r14 separate");
    rd_a(MODE_IRQ, 4'd14, 32'h0, "R2 irq r14 separate");
    rd_a(MODE_ABT, 4'd14, 32'hAB00_0014, "R5 abt r14 written");
    wr(MODE_IRQ, 4'd12, 32'h1200_0012);
    rd_a(MODE_USR, 4'd12, 32'h1200_0012, "R5 irq r12 shared with user");

    // R6 system equals user
    rd_a(MODE_SYS, 4'd13, 32'h5500_0013, "R6 sys sees user r13");
    wr(MODE_SYS, 4'd9, 32'h0000_0099);
    rd_a(MODE_USR, 4'd9, 32'h0000_0099, "R6 sys write seen by user");

    // R11 unknown mode codes
    rd_a(5'b00000, 4'd13, 32'h5500_0013, "R11 unknown mode reads user r13");
    wr(5'b10100, 4'd14, 32'h0BAD_0014);
    rd_a(MODE_USR, 4'd14, 32'h0BAD_0014, "R11 unknown mode writes user r14");
    rd_sts(5'b00111, 32'h0000_4321, 32'h0000_4321, "R11 unknown mode saved status passthrough");

    // R7 saved status per mode
    sts_wr(MODE_FIQ, 32'h0000_00F5);
    sts_wr(MODE_SVC, 32'h0000_005C);
    rd_sts(MODE_FIQ, 32'h0, 32'h0000_00F5, "R7 fiq saved status");
    rd_sts(MODE_SVC, 32'h0, 32'h0000_005C, "R7 svc saved status");
    rd_sts(MODE_IRQ, 32'h0, 32'h0, "R7 irq saved status untouched");

    // R8 user/system saved status
    rd_sts(MODE_USR, 32'h0000_1234, 32'h0000_1234, "R8 user passthrough");
    rd_sts(MODE_SYS, 32'h0000_5678, 32'h0000_5678, "R8 sys passthrough");
    sts_wr(MODE_USR, 32'h0000_0777);
    sts_wr(MODE_SYS, 32'h0000_0888);
    rd_sts(MODE_FIQ, 32'h0, 32'h0000_00F5, "R8 fiq copy unchanged by user write");
    rd_sts(MODE_SVC, 32'h0, 32'h0000_005C, "R8 svc copy unchanged");
    rd_sts(MODE_ABT, 32'h0, 32'h0, "R8 abt copy unchanged");
    rd_sts(MODE_UND, 32'h0, 32'h0, "R8 und copy unchanged");
    rd_sts(MODE_IRQ, 32'h0, 32'h0, "R8 irq copy unchanged");

    // R9 read during write
    raw(MODE_USR, 4'd3, 32'h0, 32'h3333_3333);
    raw(MODE_FIQ, 4'd10, 32'h0, 32'hF100_0010);

    // R10 independent read ports
    rd_ab(MODE_USR, 4'd3, 4'd0, 32'h3333_3333, 32'hA000_0000, "R10 two ports differ");
    rd_ab(MODE_FIQ, 4'd10, 4'd8, 32'hF100_0010, 32'hF100_0008, "R10 two fiq ports");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule